// File: doc/BRIEF.md
# Configurable Saturating Edge Counter

This block watches one digital input and counts its transitions. A strobed 4-bit control word chooses which transitions count (low-to-high, high-to-low, or both). The same word can ask for the present count to be returned as an output event, and it can zero the count at that instant. The count saturates at its top value and never wraps. A synchronous clear input resets the count and turns counting off.

A user first writes a word with the wanted edge enables. Later the user writes a word with the send bit set, together with the same enables, and takes the value from the event port one cycle after the strobe. The input is taken as already synchronous to the clock.

Top module: `edge_tally`

## Requirements
- R1: Control bit 0 (`cfg_word_i[0]`) enables counting of low-to-high transitions of `sig_i`.
- R2: Control bit 1 (`cfg_word_i[1]`) enables counting of high-to-low transitions. With bits 0 and 1 both set, both kinds are counted.
- R3: A strobe with bit 2 set (`cfg_word_i[2]`) raises `evt_vld_o` for exactly one cycle, in the cycle after the strobe. `evt_data_o` carries the count as it stood before any edge seen in the strobe cycle, zero-extended to EVT_W bits. A snapshot without bit 3 leaves the count unchanged. No event appears unless a send is requested.
- R4: Bit 3 (`cfg_word_i[3]`) together with bit 2 zeroes the count as the snapshot is taken. An enabled edge in that same cycle is kept, so the count restarts at 1. Bit 3 without bit 2 has no effect on the count.
- R5: After the asynchronous reset the count is zero, both enables are off and `evt_vld_o` is low. Toggling the input then leaves the count at zero.
- R6: A cycle with `sync_clr_i` high zeroes the count, turns both enables off and suppresses any event requested in that cycle.
- R7: The count stops at 2^CNT_W − 1. Further enabled edges leave it there.
- R8: Every control strobe replaces both enable bits. A strobe with both cleared stops all counting.
- R9: An edge is the difference between `sig_i` and its value one cycle earlier. A level held for many cycles counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_clr_i | input | 1 | Synchronous clear of count and enables |
| sig_i | input | 1 | Input whose transitions are counted |
| cfg_vld_i | input | 1 | Control word strobe |
| cfg_word_i | input | 4 | Control word: bit0 rise enable, bit1 fall enable, bit2 send, bit3 zero-on-send |
| evt_vld_o | output | 1 | Event valid, one cycle |
| evt_data_o | output | EVT_W | Snapshot count, zero-extended |

## Verification
Several properties are checked on every cycle: a send request is always answered with an event in the next cycle, and nothing else raises one. The padding bits of the event are always zero. The count never falls except through a clear, and it stays put while both enables are off. After a clear the count and enables are zero, and after a zero-on-send the count is at most one. Only the bench scenarios can show the exact count values. These are the arithmetic totals for every enable combination and edge count up to past saturation, the snapshot taken before a same-cycle edge, and the restart at one.

// File: rtl/edge_tally_pkg.sv
package edge_tally_pkg;
  localparam int unsigned CFG_W = 4;

  // control word layout, bit 0 upwards: rise, fall, send, zero
  typedef struct packed {
    logic zero;
    logic send;
    logic fall;
    logic rise;
  } cfg_t;

  typedef struct packed {
    logic fall;
    logic rise;
  } edge_sel_t;
endpackage

// File: rtl/edge_tally_detect.sv
module edge_tally_detect
  import edge_tally_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sig_i,
  output edge_sel_t hit_o
);
  logic prev_q;
  logic prev_d;

  assign prev_d = sig_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= prev_d;
  end

  always_comb begin
    hit_o.rise = sig_i & ~prev_q;
    hit_o.fall = ~sig_i & prev_q;
  end
endmodule

// File: rtl/edge_tally_ctrl.sv
module edge_tally_ctrl
  import edge_tally_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sync_clr_i,
  input  logic      cfg_vld_i,
  input  cfg_t      cfg_i,
  output edge_sel_t en_o,
  output logic      snap_o,
  output logic      zero_o
);
  edge_sel_t en_q;
  edge_sel_t en_d;
  logic      en_we;

  assign en_we = sync_clr_i | cfg_vld_i;

  always_comb begin
    en_d = en_q;
    if (sync_clr_i) begin
      en_d = '0;
    end else if (cfg_vld_i) begin
      en_d.rise = cfg_i.rise;
      en_d.fall = cfg_i.fall;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    en_q <= '0;
    else if (en_we) en_q <= en_d;
  end

  assign en_o   = en_q;
  assign snap_o = cfg_vld_i & cfg_i.send & ~sync_clr_i;
  assign zero_o = snap_o & cfg_i.zero;
endmodule

// File: rtl/edge_tally_accum.sv
module edge_tally_accum
  import edge_tally_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_clr_i,
  input  edge_sel_t        hit_i,
  input  edge_sel_t        en_i,
  input  logic             zero_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             step;
  logic             cnt_we;

  assign step   = (hit_i.rise & en_i.rise) | (hit_i.fall & en_i.fall);
  assign cnt_we = sync_clr_i | zero_i | step;

  always_comb begin
    cnt_d = cnt_q;
    if (sync_clr_i) begin
      cnt_d = '0;
    end else if (zero_i) begin
      cnt_d = step ? CNT_ONE : '0;
    end else if (step && (cnt_q != CNT_MAX)) begin
      cnt_d = cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/edge_tally.sv
module edge_tally
  import edge_tally_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned EVT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_clr_i,
  input  logic             sig_i,
  input  logic             cfg_vld_i,
  input  logic [CFG_W-1:0] cfg_word_i,
  output logic             evt_vld_o,
  output logic [EVT_W-1:0] evt_data_o
);
  localparam int unsigned PAD_W = EVT_W - CNT_W;

  edge_sel_t        hit;
  edge_sel_t        en_q;
  logic             snap;
  logic             zero;
  logic [CNT_W-1:0] cnt_q;
  logic [EVT_W-1:0] cnt_ext;
  logic             vld_q, vld_d;
  logic [EVT_W-1:0] data_q, data_d;
  cfg_t             cfg;

  assign cfg = cfg_t'(cfg_word_i);

  edge_tally_detect det_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (sig_i),
    .hit_o (hit)
  );

  edge_tally_ctrl ctl_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_clr_i(sync_clr_i),
    .cfg_vld_i (cfg_vld_i),
    .cfg_i     (cfg),
    .en_o      (en_q),
    .snap_o    (snap),
    .zero_o    (zero)
  );

  edge_tally_accum #(.CNT_W(CNT_W)) acc_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_clr_i(sync_clr_i),
    .hit_i     (hit),
    .en_i      (en_q),
    .zero_i    (zero),
    .cnt_o     (cnt_q)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign cnt_ext = {{PAD_W{1'b0}}, cnt_q};
    end else begin : g_nopad
      assign cnt_ext = cnt_q[EVT_W-1:0];
    end
  endgenerate

  assign vld_d  = snap;
  assign data_d = cnt_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= 1'b0;
    else         vld_q <= vld_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   data_q <= '0;
    else if (snap) data_q <= data_d;
  end

  assign evt_vld_o  = vld_q;
  assign evt_data_o = data_q;
endmodule

// File: rtl/edge_tally_chk.sv
module edge_tally_chk #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned EVT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sync_clr_i,
  input logic             cfg_vld_i,
  input logic [3:0]       cfg_word_i,
  input logic             evt_vld_o,
  input logic [EVT_W-1:0] evt_data_o,
  input logic [1:0]       en_q,
  input logic [CNT_W-1:0] cnt_q
);
  initial begin
    param_ok_chk: assert (CNT_W >= 2 && EVT_W >= CNT_W)
      else $error("edge_tally: CNT_W must be at least 2 and no wider than EVT_W");
  end

  // R3
  send_answered_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_vld_i && cfg_word_i[2] && !sync_clr_i) |=> evt_vld_o);

  // R3
  no_spurious_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_vld_i && cfg_word_i[2]) |=> !evt_vld_o);

  generate
    if (EVT_W > CNT_W) begin : g_pad_chk
      // R3
      zero_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_vld_o |-> (evt_data_o[EVT_W-1:CNT_W] == '0));
    end
  endgenerate

  // R4
  zero_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_vld_i && cfg_word_i[2] && cfg_word_i[3]) |=> (cnt_q <= 1));

  // R6
  sync_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_clr_i |=> (cnt_q == '0 && en_q == 2'b00 && !evt_vld_o));

  // R7
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sync_clr_i || (cfg_vld_i && cfg_word_i[2] && cfg_word_i[3])) |=> (cnt_q >= $past(cnt_q)));

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == 2'b00 && !cfg_vld_i && !sync_clr_i) |=> $stable(cnt_q));
endmodule

bind edge_tally edge_tally_chk #(.CNT_W(CNT_W), .EVT_W(EVT_W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sync_clr_i(sync_clr_i),
  .cfg_vld_i (cfg_vld_i),
  .cfg_word_i(cfg_word_i),
  .evt_vld_o (evt_vld_o),
  .evt_data_o(evt_data_o),
  .en_q      (en_q),
  .cnt_q     (cnt_q)
);

// File: tb/edge_tally_tb_top.sv
`timescale 1ns/1ps
module edge_tally_tb_top;
  localparam int CNT_W = 3;
  localparam int EVT_W = 8;
  localparam int SAT   = (1 << CNT_W) - 1;

  logic             clk_i = 1'b0;
  logic             rst_ni;
  logic             sync_clr_i;
  logic             sig_i;
  logic             cfg_vld_i;
  logic [3:0]       cfg_word_i;
  logic             evt_vld_o;
  logic [EVT_W-1:0] evt_data_o;

  int n_tot = 0;
  int n_bad = 0;
  logic [1:0] cur_en = 2'b00;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;

  edge_tally #(.CNT_W(CNT_W), .EVT_W(EVT_W)) dut_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_clr_i(sync_clr_i),
    .sig_i     (sig_i),
    .cfg_vld_i (cfg_vld_i),
    .cfg_word_i(cfg_word_i),
    .evt_vld_o (evt_vld_o),
    .evt_data_o(evt_data_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tot++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // enable-only write, no send: must not raise an event
  task automatic set_en(input logic [1:0] en);
    @(negedge clk_i);
    cfg_vld_i = 1'b1; cfg_word_i = {2'b00, en}; cur_en = en;
    @(negedge clk_i);
    cfg_vld_i = 1'b0;
    chk("R3 no event without send", int'(evt_vld_o), 0);
  endtask

  task automatic fetch(input bit zero, output int val);
    @(negedge clk_i);
    cfg_vld_i = 1'b1; cfg_word_i = {zero, 1'b1, cur_en};
    @(negedge clk_i);
    cfg_vld_i = 1'b0;
    chk("R3 event strobe", int'(evt_vld_o), 1);
    chk("R3 zero extension", int'(evt_data_o[EVT_W-1:CNT_W]), 0);
    val = int'(evt_data_o);
    @(negedge clk_i);
    chk("R3 single-cycle strobe", int'(evt_vld_o), 0);
  endtask

  task automatic toggle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); sig_i = 1'b1;
      @(negedge clk_i); sig_i = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_tot++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
    end
  end

  initial begin
    int v;
    rst_ni = 1'b0; sync_clr_i = 1'b0; sig_i = 1'b0;
    cfg_vld_i = 1'b0; cfg_word_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R5 no event after reset", int'(evt_vld_o), 0);
    fetch(1'b0, v); chk("R5 count zero after reset", v, 0);
    toggle(3);
    fetch(1'b0, v); chk("R5 enables off after reset", v, 0);

    // sweep: every enable combination, 0..SAT+2 toggles
    for (int en = 0; en < 4; en++) begin
      for (int n = 0; n <= SAT + 2; n++) begin
        int per, exp;
        per = (en & 1) + ((en >> 1) & 1);
        exp = (n * per > SAT) ? SAT : n * per;
        set_en(en[1:0]);
        fetch(1'b1, v);
        toggle(n);
        fetch(1'b1, v);
        if (n * per > SAT)  chk("R7 saturation", v, exp);
        else if (en == 0)   chk("R8 no enables no count", v, exp);
        else if (en == 1)   chk("R1 rising count", v, exp);
        else                chk("R2 falling/both count", v, exp);
      end
    end

    // R9: level held high counts once
    set_en(2'b01); fetch(1'b1, v);
    @(negedge clk_i); sig_i = 1'b1;
    repeat (6) @(negedge clk_i);
    sig_i = 1'b0;
    fetch(1'b1, v); chk("R9 held level counts once", v, 1);

    // R4: zero bit alone leaves count; R3: plain snapshot leaves count
    toggle(2);
    @(negedge clk_i); cfg_vld_i = 1'b1; cfg_word_i = {2'b10, cur_en};
    @(negedge clk_i); cfg_vld_i = 1'b0;
    chk("R4 zero bit alone no event", int'(evt_vld_o), 0);
    fetch(1'b0, v); chk("R4 zero bit alone keeps count", v, 2);
    fetch(1'b0, v); chk("R3 snapshot keeps count", v, 2);

    // R4: edge in the snapshot-and-zero cycle restarts at one
    @(negedge clk_i); sig_i = 1'b1; cfg_vld_i = 1'b1; cfg_word_i = {2'b11, cur_en};
    @(negedge clk_i); cfg_vld_i = 1'b0;
    chk("R4 snapshot before zero", int'(evt_data_o), 2);
    @(negedge clk_i); sig_i = 1'b0;
    fetch(1'b0, v); chk("R4 restart at one", v, 1);

    // R3: edge in plain snapshot cycle is excluded from that snapshot
    @(negedge clk_i); sig_i = 1'b1; cfg_vld_i = 1'b1; cfg_word_i = {2'b01, cur_en};
    @(negedge clk_i); cfg_vld_i = 1'b0;
    chk("R3 snapshot precedes same-cycle edge", int'(evt_data_o), 1);
    @(negedge clk_i); sig_i = 1'b0;
    fetch(1'b0, v); chk("R3 same-cycle edge counted later", v, 2);

    // R8: clearing enables stops counting
    set_en(2'b11); fetch(1'b1, v);
    toggle(1);
    set_en(2'b00);
    toggle(3);
    fetch(1'b0, v); chk("R8 write replaces enables", v, 2);

    // R6: synchronous clear
    set_en(2'b01); toggle(2);
    @(negedge clk_i); sync_clr_i = 1'b1;
    @(negedge clk_i); sync_clr_i = 1'b0;
    toggle(2);
    fetch(1'b0, v); chk("R6 clear zeroes count and enables", v, 0);
    set_en(2'b01); toggle(1);
    @(negedge clk_i); sync_clr_i = 1'b1; cfg_vld_i = 1'b1; cfg_word_i = {2'b01, cur_en};
    @(negedge clk_i); sync_clr_i = 1'b0; cfg_vld_i = 1'b0;
    chk("R6 clear suppresses event", int'(evt_vld_o), 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end
endmodule